// File: doc/BRIEF.md
# Four-Port Selectable-Policy Memory Arbiter

This block decides which of four host ports owns a shared memory device next. Each port raises a request line and presents the length of the transfer it wants. The arbiter issues a one-hot grant with a valid flag. The grant stays in place until the memory side pulses a done signal. After that the next decision is made.

A two-bit policy selector picks how that decision is made. The choices are plain rotation, rotation with a per-port quota of back-to-back transfers, and a bandwidth scheme. In the bandwidth scheme, ports build up weight each round and pay for the words they move. A policy change is only picked up while no grant is outstanding. At that moment every quota and every accumulator is cleared.

Top module: `wrr_port_arbiter`

## Requirements
- R1: Out of reset, grant is all zeros and grant_valid is low. At all times grant has at most one bit set, and grant_valid is high exactly when grant is non-zero.
- R2: While idle, with the selected policy matching the active one, a grant appears on the clock edge after at least one request is sampled. The granted port is one that was requesting. With no request, no grant is issued.
- R3: A grant holds unchanged until xfer_done is sampled high, and it drops on that edge. The next grant can come at the earliest one edge later. A pulse on xfer_done while idle has no effect.
- R4: Policy codes 0 and 3 are plain rotation. The search starts at the port after the last granted one, wrapping from 3 to 0, and skips ports that are not requesting. After reset the search starts at port 0.
- R5: Policy code 1 is the quota policy. A port granted after another port (or after a clear) has its credit set to its weight, with a weight of 0 counted as 1. Each completed transfer by that port takes one credit away. It keeps the grant while it still requests and has credit left. Otherwise rotation continues from the port after it.
- R6: Under policy code 1, a port that drops its request gives up its turn. Its next grant after another port loads a fresh quota.
- R7: Policy code 2 is the bandwidth policy. In each decision, every requesting port adds its weight to its accumulator, saturating at 2^AW-1. The requesting port with the largest sum wins, and ties go to the first in rotation order after the last granted port. The winner's transfer length is then subtracted, with a floor of 0.
- R8: When the selector differs from the active policy while idle, that edge only adopts the new policy and clears all credits and accumulators. No grant is issued on that edge. While a grant is outstanding, the selector is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | NPORT | Per-port request lines |
| xfer_len | input | NPORT*LW | Per-port transfer length in words, port i at bits [i*LW +: LW] |
| xfer_done | input | 1 | Pulse ending the granted transfer |
| mode_sel | input | 2 | Policy: 0 rotation, 1 quota, 2 bandwidth, 3 rotation |
| weight | input | NPORT*WW | Per-port weight, port i at bits [i*WW +: WW] |
| grant | output | NPORT | One-hot grant |
| grant_valid | output | 1 | A grant is outstanding |

## Verification
Every result is a single register stage away from the inputs that cause it. A grant is due on the edge after the requests are sampled, and a release on the edge after xfer_done. A policy switch costs one edge with no grant before normal arbitration resumes. The bench drives inputs on the falling edge, advances its own model of the state by exactly one step per rising edge, and compares grant and grant_valid on the next falling edge. Every comparison therefore lands in the cycle in which the design's registers have just changed.

// File: rtl/arb_pkg.sv
package arb_pkg;
    typedef enum logic [1:0] {
        MODE_RR     = 2'd0,
        MODE_CNT    = 2'd1,
        MODE_BW     = 2'd2,
        MODE_RR_ALT = 2'd3
    } arb_mode_t;
endpackage

// File: rtl/arb_rr_pick.sv
// Rotating first-requester search starting after the last granted port.
module arb_rr_pick #(
    parameter  int NPORT = 4,
    localparam int IW    = (NPORT > 1) ? $clog2(NPORT) : 1
) (
    input  logic [NPORT-1:0] req,
    input  logic [IW-1:0]    last,
    output logic             found,
    output logic [IW-1:0]    idx
);
    always_comb begin
        found = 1'b0;
        idx   = last;
        for (int k = 1; k <= NPORT; k++) begin
            int p;
            p = (int'(last) + k) % NPORT;
            if (!found && req[p]) begin
                found = 1'b1;
                idx   = IW'(p);
            end
        end
    end
endmodule

// File: rtl/arb_bw_pick.sv
// Largest-value search among requesters; ties resolved in rotation order.
module arb_bw_pick #(
    parameter  int NPORT = 4,
    parameter  int AW    = 12,
    localparam int IW    = (NPORT > 1) ? $clog2(NPORT) : 1
) (
    input  logic [NPORT-1:0]         req,
    input  logic [IW-1:0]            last,
    input  logic [NPORT-1:0][AW-1:0] vals,
    output logic [IW-1:0]            idx
);
    always_comb begin
        logic          have;
        logic [AW-1:0] best;
        have = 1'b0;
        best = '0;
        idx  = last;
        for (int k = 1; k <= NPORT; k++) begin
            int p;
            p = (int'(last) + k) % NPORT;
            if (req[p] && (!have || vals[p] > best)) begin
                have = 1'b1;
                best = vals[p];
                idx  = IW'(p);
            end
        end
    end
endmodule

// File: rtl/wrr_port_arbiter.sv
module wrr_port_arbiter
    import arb_pkg::*;
#(
    parameter int NPORT = 4,
    parameter int WW    = 8,
    parameter int LW    = 8,
    parameter int AW    = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NPORT-1:0]    req,
    input  logic [NPORT*LW-1:0] xfer_len,
    input  logic                xfer_done,
    input  logic [1:0]          mode_sel,
    input  logic [NPORT*WW-1:0] weight,
    output logic [NPORT-1:0]    grant,
    output logic                grant_valid
);
    localparam int            IW   = (NPORT > 1) ? $clog2(NPORT) : 1;
    localparam logic [AW-1:0] AMAX = '1;

    typedef struct packed {
        logic                     busy;
        logic [NPORT-1:0]         grant;
        logic [IW-1:0]            last;
        arb_mode_t                mode;
        logic [NPORT-1:0][WW-1:0] cred;
        logic [NPORT-1:0][AW-1:0] acc;
    } arb_state_t;

    arb_state_t st_q, st_d;

    logic [NPORT-1:0][AW-1:0] sum;
    logic                     rr_found;
    logic [IW-1:0]            rr_idx, bw_idx, win;
    logic [WW-1:0]            wt;
    logic [LW-1:0]            ln;

    arb_rr_pick #(.NPORT(NPORT)) u_rr (
        .req  (req),
        .last (st_q.last),
        .found(rr_found),
        .idx  (rr_idx)
    );

    arb_bw_pick #(.NPORT(NPORT), .AW(AW)) u_bw (
        .req (req),
        .last(st_q.last),
        .vals(sum),
        .idx (bw_idx)
    );

    // Saturating accumulator plus weight for every port
    always_comb begin
        for (int i = 0; i < NPORT; i++) begin
            logic [AW:0] ext;
            ext    = {1'b0, st_q.acc[i]} + (AW+1)'(weight[i*WW +: WW]);
            sum[i] = ext[AW] ? AMAX : ext[AW-1:0];
        end
    end

    always_comb begin
        st_d = st_q;
        win  = rr_idx;
        wt   = '0;
        ln   = '0;
        if (st_q.busy) begin
            if (xfer_done) begin
                st_d.busy  = 1'b0;
                st_d.grant = '0;
                if (st_q.mode == MODE_CNT && st_q.cred[st_q.last] != '0)
                    st_d.cred[st_q.last] = st_q.cred[st_q.last] - WW'(1);
            end
        end else if (arb_mode_t'(mode_sel) != st_q.mode) begin
            st_d.mode = arb_mode_t'(mode_sel);
            st_d.cred = '0;
            st_d.acc  = '0;
        end else if (rr_found) begin
            case (st_q.mode)
                MODE_CNT: begin
                    if (req[st_q.last] && st_q.cred[st_q.last] != '0) begin
                        win = st_q.last;
                    end else begin
                        win = rr_idx;
                        wt  = weight[rr_idx*WW +: WW];
                        st_d.cred[rr_idx] = (wt == '0) ? WW'(1) : wt;
                    end
                end
                MODE_BW: begin
                    win = bw_idx;
                    for (int i = 0; i < NPORT; i++)
                        if (req[i]) st_d.acc[i] = sum[i];
                    ln = xfer_len[bw_idx*LW +: LW];
                    st_d.acc[bw_idx] = (sum[bw_idx] > AW'(ln)) ? sum[bw_idx] - AW'(ln) : '0;
                end
                default: win = rr_idx;
            endcase
            st_d.busy  = 1'b1;
            st_d.grant = NPORT'(1) << win;
            st_d.last  = win;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.busy  <= 1'b0;
            st_q.grant <= '0;
            st_q.last  <= IW'(NPORT - 1);
            st_q.mode  <= MODE_RR;
            st_q.cred  <= '0;
            st_q.acc   <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign grant       = st_q.grant;
    assign grant_valid = st_q.busy;

    p_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant) && (grant_valid == (grant != '0)));

    p_from_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid && !$past(grant_valid)) |-> ((grant & $past(req)) != '0));

    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid && !xfer_done) |=> (grant_valid && $stable(grant)));

    p_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid && xfer_done) |=> !grant_valid);

    p_mode_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(st_q.mode) |-> (!$past(grant_valid) && !grant_valid));
endmodule

// File: tb/sim_wrr_port_arbiter.sv
`timescale 1ns/1ps
module sim_wrr_port_arbiter;
    localparam int N = 4, WW = 8, LW = 8, AW = 12;
    localparam int AMAX = (1 << AW) - 1;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [N-1:0]    req = '0;
    logic [N*LW-1:0] xfer_len = '0;
    logic            xfer_done = 1'b0;
    logic [1:0]      mode_sel = 2'd0;
    logic [N*WW-1:0] weight = '0;
    logic [N-1:0]    grant;
    logic            grant_valid;

    always #2.5 clk = ~clk;

    wrr_port_arbiter #(.NPORT(N), .WW(WW), .LW(LW), .AW(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .req(req), .xfer_len(xfer_len),
        .xfer_done(xfer_done), .mode_sel(mode_sel), .weight(weight),
        .grant(grant), .grant_valid(grant_valid)
    );

    int n_chk = 0, n_bad = 0;
    string tag = "R1";

    // Reference state, advanced once per rising edge
    logic         m_busy;
    logic [N-1:0] m_grant;
    int           m_last;
    logic [1:0]   m_mode;
    int           m_cred[N];
    int           m_acc[N];

    task automatic m_reset();
        m_busy = 0; m_grant = '0; m_last = N - 1; m_mode = 2'd0;
        for (int i = 0; i < N; i++) begin m_cred[i] = 0; m_acc[i] = 0; end
    endtask

    function automatic int rr_next(logic [N-1:0] r, int from);
        for (int k = 1; k <= N; k++) if (r[(from + k) % N]) return (from + k) % N;
        return from;
    endfunction

    task automatic m_step();
        int win, w, l, best, p;
        int s[N];
        if (m_busy) begin
            if (xfer_done) begin
                m_busy = 0; m_grant = '0;
                if (m_mode == 2'd1 && m_cred[m_last] > 0) m_cred[m_last]--;
            end
        end else if (mode_sel != m_mode) begin
            m_mode = mode_sel;
            for (int i = 0; i < N; i++) begin m_cred[i] = 0; m_acc[i] = 0; end
        end else if (req != '0) begin
            if (m_mode == 2'd1) begin
                if (req[m_last] && m_cred[m_last] > 0) win = m_last;
                else begin
                    win = rr_next(req, m_last);
                    w = int'(weight[win*WW +: WW]);
                    m_cred[win] = (w == 0) ? 1 : w;
                end
            end else if (m_mode == 2'd2) begin
                best = -1; win = m_last;
                for (int i = 0; i < N; i++) begin
                    s[i] = m_acc[i] + int'(weight[i*WW +: WW]);
                    if (s[i] > AMAX) s[i] = AMAX;
                end
                for (int k = 1; k <= N; k++) begin
                    p = (m_last + k) % N;
                    if (req[p] && s[p] > best) begin best = s[p]; win = p; end
                end
                for (int i = 0; i < N; i++) if (req[i]) m_acc[i] = s[i];
                l = int'(xfer_len[win*LW +: LW]);
                m_acc[win] = (s[win] > l) ? s[win] - l : 0;
            end else begin
                win = rr_next(req, m_last);
            end
            m_busy = 1; m_grant = N'(1) << win; m_last = win;
        end
    endtask

    task automatic check_model();
        n_chk++;
        if (grant !== m_grant || grant_valid !== m_busy) begin
            n_bad++;
            $display("FAIL %s: grant=%b valid=%b expected grant=%b valid=%b at %0t",
                     tag, grant, grant_valid, m_grant, m_busy, $time);
        end
    endtask

    task automatic check_val(string t, logic [N-1:0] exp_g);
        n_chk++;
        if (grant !== exp_g) begin
            n_bad++;
            $display("FAIL %s: grant=%b expected %b", t, grant, exp_g);
        end
    endtask

    // Inputs are set at a falling edge; step the model, compare at the next falling edge
    task automatic tick();
        m_step();
        @(negedge clk);
        check_model();
    endtask

    task automatic rand_inputs(int done_pct);
        req = N'($urandom);
        xfer_done = m_busy ? (($urandom % 100) < done_pct) : ($urandom % 4 == 0);
        for (int i = 0; i < N; i++) xfer_len[i*LW +: LW] = LW'($urandom % 16);
    endtask

    initial begin
        #(5.0 * 150000);
        n_bad++;
        $display("FAIL watchdog: run hung, expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        m_reset();
        repeat (3) @(negedge clk);
        tag = "R1";
        check_model();
        check_val("R1 reset", '0);
        rst_n = 1'b1;

        // R3: done while idle has no effect
        tag = "R3";
        req = '0; xfer_done = 1'b1;
        repeat (3) tick();
        check_val("R3 idle done", '0);

        // R4: all request after reset -> port 0 first, then rotation
        tag = "R4";
        xfer_done = 1'b0; req = 4'b1111;
        tick();
        check_val("R4 first", 4'b0001);
        for (int c = 0; c < 12; c++) begin xfer_done = m_busy; tick(); end
        req = 4'b1010;
        for (int c = 0; c < 10; c++) begin xfer_done = m_busy; tick(); end

        // R2: no request -> no grant
        tag = "R2";
        req = '0; xfer_done = 1'b1; tick();
        xfer_done = 1'b0; repeat (3) tick();
        check_val("R2 no req", '0);

        // R8 + R5: switch to quota policy, uneven weights
        tag = "R8";
        mode_sel = 2'd1; weight = {8'd0, 8'd1, 8'd3, 8'd2};
        req = 4'b0111; tick();
        check_val("R8 switch cycle", '0);
        tag = "R5";
        for (int c = 0; c < 30; c++) begin xfer_done = m_busy; tick(); end
        // R6: port drops request mid-quota
        tag = "R6";
        for (int c = 0; c < 40; c++) begin
            req = (c % 7 < 3) ? 4'b0110 : 4'b1101;
            xfer_done = m_busy && (c % 2 == 0); tick();
        end

        // R7: bandwidth policy, ties and subtraction
        tag = "R7";
        req = '0; xfer_done = m_busy; tick();
        xfer_done = 1'b0; mode_sel = 2'd2; weight = {8'd4, 8'd4, 8'd4, 8'd4};
        xfer_len = {8'd9, 8'd2, 8'd5, 8'd1};
        tick();
        req = 4'b1111;
        for (int c = 0; c < 40; c++) begin xfer_done = m_busy; tick(); end
        weight = {8'd200, 8'd10, 8'd3, 8'd1};
        for (int c = 0; c < 400; c++) begin rand_inputs(50); tick(); end

        // R8: random policy changes while busy and idle
        tag = "R8";
        for (int c = 0; c < 6000; c++) begin
            if ($urandom % 40 == 0) mode_sel = 2'($urandom);
            if ($urandom % 60 == 0)
                for (int i = 0; i < N; i++) weight[i*WW +: WW] = WW'($urandom % 5);
            rand_inputs(40);
            tick();
        end

        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule